// File: doc/BRIEF.md
# Sequential Array Maximum Finder

This block scans a fixed table of signed words and reports the largest one. The whole table is presented at once on a flat input bus. A single-cycle start request launches a scan. The block then examines one entry per clock, keeping a running best value, so the hardware cost is one comparator and one multiplexer rather than a full comparison tree.

Control is a two-state machine with an idle state and a scanning state. While scanning, the block raises a busy flag. It keeps the first entry as its initial best value and replaces that value only when a later entry is strictly larger. After the final entry it returns to idle, pulses a completion strobe for one cycle, and publishes the result on a held output. The caller must keep the table stable from the start request until the completion strobe.

Top module: `array_max_scan`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the outputs are max_out = 0, done = 0 and busy = 0.
- R2: When start is high at a rising edge while the block is idle, busy is high from the next cycle on.
- R3: A scan reads one entry per clock. busy stays high for exactly 19 cycles, and done is high in the cycle after the 20th rising edge, counting the edge that sampled start.
- R4: Entry i occupies bits arr_flat[i*16 +: 16] and is a two's-complement signed value. Comparisons are signed, so 0x7FFF is larger than 0xFFFF.
- R5: At completion, max_out equals the largest of the 20 entries. This holds when the largest entry is at index 0, at index 19, somewhere in between, or when all entries are equal.
- R6: done is high for exactly one cycle per scan and is never high at the same time as busy.
- R7: A start request while busy is ignored. The scan in progress ends at its original time and produces its original result.
- R8: max_out changes only at a completion. Between completions it holds its value, even when arr_flat or start change.
- R9: After the last entry the block is idle again. A start in the same cycle as done begins a new scan at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Scan request, sampled while idle |
| arr_flat | input | 320 | Twenty signed 16-bit entries; entry i at bits i*16 +: 16 |
| max_out | output | 16 | Largest entry of the last completed scan |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | High while a scan is in progress |

## Verification
A wrong scan index would either make done arrive early or late, which shows at the ports within one scan, or make the block skip or repeat an entry. The skipped-entry case shows in max_out only when the largest value sits at the affected position, so the tests place the peak at index 0, at index 19 and at interior positions. A running maximum that uses an unsigned compare, or that keeps the wrong value, is exposed at the next completion by the mixed-sign patterns. A machine that accepts start while busy changes the timing of done inside that same scan.

// File: rtl/array_max_pkg.sv
package array_max_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

endpackage

// File: rtl/array_max_ctrl.sv
module array_max_ctrl
    import array_max_pkg::*;
#(
    parameter int N_ENTRIES = 20,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [IDX_W-1:0] idx,
    output logic             load,
    output logic             step,
    output logic             last,
    output logic             busy,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

    typedef struct packed {
        scan_state_e      state;
        logic [IDX_W-1:0] idx;
        logic             done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        case (ctrl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctrl_d.state = ST_SCAN;
                    ctrl_d.idx   = IDX_W'(1);
                end
            end
            ST_SCAN: begin
                if (ctrl_q.idx == LAST_IDX) begin
                    ctrl_d.state = ST_IDLE;
                    ctrl_d.idx   = '0;
                    ctrl_d.done  = 1'b1;
                end else begin
                    ctrl_d.idx = ctrl_q.idx + IDX_W'(1);
                end
            end
            default: ctrl_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign idx  = ctrl_q.idx;
    assign load = (ctrl_q.state == ST_IDLE) && start;
    assign step = (ctrl_q.state == ST_SCAN);
    assign last = step && (ctrl_q.idx == LAST_IDX);
    assign busy = step;
    assign done = ctrl_q.done;

    // R6: completion strobe lasts one cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.done |=> !ctrl_q.done);

    // R6: never busy and done together
    p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R3: index stays inside the table while scanning
    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (ctrl_q.idx >= IDX_W'(1)) && (ctrl_q.idx <= LAST_IDX));

    // R7: a scan before its last entry always advances by one, start or not
    p_scan_advances_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last) |=> (ctrl_q.state == ST_SCAN) &&
                            (ctrl_q.idx == IDX_W'($past(ctrl_q.idx) + IDX_W'(1))));

    // R9: the last entry returns the machine to idle with done
    p_last_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (ctrl_q.state == ST_IDLE) && ctrl_q.done);

endmodule

// File: rtl/array_max_dpath.sv
module array_max_dpath #(
    parameter int N_ENTRIES = 20,
    parameter int DATA_W    = 16,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int FLAT_W   = N_ENTRIES * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAT_W-1:0] arr_flat,
    input  logic [IDX_W-1:0]  idx,
    input  logic              load,
    input  logic              step,
    input  logic              last,
    output logic [DATA_W-1:0] result
);

    typedef struct packed {
        logic signed [DATA_W-1:0] run;
        logic signed [DATA_W-1:0] res;
    } dp_t;

    dp_t dp_d, dp_q;
    logic signed [DATA_W-1:0] elem;
    logic [DATA_W-1:0] lanes [N_ENTRIES];

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_lane
        assign lanes[g] = arr_flat[g*DATA_W +: DATA_W];
    end

    always_comb begin
        elem = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (idx == IDX_W'(i)) elem = lanes[i];
        end
    end

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.run = elem;
        end else if (step && (elem > dp_q.run)) begin
            dp_d.run = elem;
        end
        if (last) begin
            dp_d.res = (elem > dp_q.run) ? elem : dp_q.run;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign result = dp_q.res;

    // R8: the published result moves only on the final entry
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(dp_q.res));

    // R5: the result is never below the running best it was built from
    p_result_ge_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (dp_q.res >= $past(dp_q.run)));

    // R4: the running best never decreases during a scan
    p_run_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last) |=> (dp_q.run >= $past(dp_q.run)));

endmodule

// File: rtl/array_max_scan.sv
module array_max_scan #(
    parameter int N_ENTRIES = 20,
    parameter int DATA_W    = 16,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int FLAT_W   = N_ENTRIES * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FLAT_W-1:0] arr_flat,
    output logic [DATA_W-1:0] max_out,
    output logic              done,
    output logic              busy
);

    logic [IDX_W-1:0] idx;
    logic load, step, last;

    array_max_ctrl #(.N_ENTRIES(N_ENTRIES)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .idx   (idx),
        .load  (load),
        .step  (step),
        .last  (last),
        .busy  (busy),
        .done  (done)
    );

    array_max_dpath #(.N_ENTRIES(N_ENTRIES), .DATA_W(DATA_W)) dpath_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .arr_flat (arr_flat),
        .idx      (idx),
        .load     (load),
        .step     (step),
        .last     (last),
        .result   (max_out)
    );

endmodule

// File: tb/array_max_scan_tb.sv
`timescale 1ns/1ps
module array_max_scan_tb_top;

    localparam int N = 20;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N*W-1:0] arr = '0;
    logic [W-1:0] max_out;
    logic done, busy;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    string tag = "R1";

    // behavioural reference state
    bit m_busy = 0;
    bit m_done = 0;
    int m_cnt = 0;
    int m_max = 0;

    always #2 clk = ~clk;

    array_max_scan dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .arr_flat(arr),
        .max_out(max_out), .done(done), .busy(busy)
    );

    function automatic int table_max();
        int best = $signed(arr[0 +: W]);
        for (int i = 1; i < N; i++) begin
            if ($signed(arr[i*W +: W]) > best) best = $signed(arr[i*W +: W]);
        end
        return best;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_cnt <= 0; m_max <= 0;
        end else if (m_busy) begin
            if (m_cnt == 18) begin
                m_busy <= 0; m_done <= 1; m_max <= table_max();
            end else begin
                m_done <= 0;
            end
            m_cnt <= m_cnt + 1;
        end else begin
            m_done <= 0;
            if (start) begin
                m_busy <= 1; m_cnt <= 0;
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        vectors++;
        if (busy !== m_busy || done !== m_done ||
            $signed(max_out) !== m_max[W-1:0] && max_out !== m_max[W-1:0]) begin
            fails++;
            $display("FAIL %s: busy=%0b done=%0b max=%0d expected busy=%0b done=%0b max=%0d",
                     tag, busy, done, $signed(max_out), m_busy, m_done, m_max);
        end
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic put(int i, int v);
        arr[i*W +: W] = W'(v);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic scan_and_wait();
        pulse_start();
        repeat (22) @(negedge clk);
    endtask

    initial begin
        // R1: reset values
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R5: ascending, peak at index 19
        tag = "R3";
        for (int i = 0; i < N; i++) put(i, i * 3 - 10);
        scan_and_wait();

        // R5: peak at index 0
        tag = "R5";
        for (int i = 0; i < N; i++) put(i, 500 - i * 7);
        scan_and_wait();

        // R5: all equal at the most negative value
        for (int i = 0; i < N; i++) put(i, -32768);
        scan_and_wait();

        // R4: signed ordering, 0x7FFF against 0xFFFF
        tag = "R4";
        for (int i = 0; i < N; i++) put(i, -1);
        put(11, 32767);
        scan_and_wait();
        for (int i = 0; i < N; i++) put(i, -200 - i);
        put(7, -5);
        scan_and_wait();

        // R7: start requests while busy are ignored
        tag = "R7";
        for (int i = 0; i < N; i++) put(i, (i * 37) % 101 - 50);
        pulse_start();
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (9) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (12) @(negedge clk);

        // R8: result holds while the table changes in idle
        tag = "R8";
        for (int i = 0; i < N; i++) put(i, 30000 - i);
        repeat (6) @(negedge clk);

        // R9: start in the done cycle begins a new scan immediately
        tag = "R9";
        for (int i = 0; i < N; i++) put(i, i * 11);
        pulse_start();
        while (!done) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (24) @(negedge clk);

        // R6: interior peak, done single pulse covered by per-cycle compare
        tag = "R6";
        for (int i = 0; i < N; i++) put(i, -(i - 9) * (i - 9));
        scan_and_wait();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule